// File: doc/BRIEF.md
# Cache Performance Monitor

This block sits beside a cache pipeline and counts three kinds of access events: page hits, page misses and accesses that bypass the cache. The pipeline reports each event as a single-cycle pulse. Software controls counting through one 32-bit control word. That word holds a run bit, a timer-enable bit, a mode bit and a 24-bit window length. The three counts are read back as registered outputs.

An optional down-counting timer bounds the measurement interval. Each time the run bit goes from low to high, the three counters are cleared and the timer is loaded with the programmed window. In free-running mode the timer only cuts counting off when it expires. In windowed mode, events count only while a timer window is open. A build-time parameter removes the monitor completely. A read-only build-configuration word reports whether the monitor is present.

Top module: `cache_perf_mon`

## Requirements
- R1: After a synchronous reset, the control word, the remaining-timer output and all three counters read zero.
- R2: The control word uses bit 0 as run, bit 1 as timer enable, bit 2 as mode and bits 31:8 as the window length. Bits 7:3 always read zero. A write becomes visible on the cycle after the write strobe.
- R3: When a write has bit 1 clear, the stored window field is zero, whatever the written data holds in bits 31:8.
- R4: A write that takes the run bit from 0 to 1 clears all three counters and loads the timer with the stored window field. An event pulse in that same cycle is not counted.
- R5: While counting is allowed, each pulse on the hit, miss or bypass input adds exactly one to its own counter. Pulses that arrive in the same cycle are counted independently.
- R6: While run and timer enable are both set, the timer drops by one every cycle. It stays at zero once it reaches zero.
- R7: Mode 0 (bit 2 = 0) is free-running. With the timer disabled, counting has no time limit. With the timer enabled, counting stops when the timer reaches zero.
- R8: Mode 1 (bit 2 = 1) counts only while the timer is enabled and nonzero. With the timer disabled, mode 1 counts nothing.
- R9: While the run bit is clear, the counters and the timer keep their values. Events are ignored.
- R10: A counter that holds all ones stays at all ones on further events.
- R11: Bit 4 of the build-configuration word equals the PRESENT parameter. When PRESENT is 0, every other output is zero and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ev_hit | input | 1 | Page hit pulse |
| ev_miss | input | 1 | Page miss pulse |
| ev_byp | input | 1 | Bypass access pulse |
| ctrl_rdata | output | 32 | Stored control word |
| build_cfg | output | 32 | Build configuration; bit 4 = monitor present |
| timer_left | output | 24 | Remaining timer window |
| hit_count | output | CNT_W | Page hit counter |
| miss_count | output | CNT_W | Page miss counter |
| byp_count | output | CNT_W | Bypass counter |

## Verification
The embedded properties check these rules on every cycle:
- the timer steps down by exactly one and then rests at zero;
- a stopped monitor freezes both its timer and its counters;
- a counter moves only by single steps, is zeroed on an enable edge and holds at all ones;
- a cleared timer-enable bit always comes with a zero window field.

Only the bench's scenarios can show the following:
- that the window admits exactly the programmed number of event cycles;
- that the two modes differ when the timer is off;
- that an event in the enabling cycle is dropped;
- that the absent build drives every output to zero.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int CTRL_W      = 32;
  localparam int RUN_BIT     = 0;
  localparam int TEN_BIT     = 1;
  localparam int MODE_BIT    = 2;
  localparam int WIN_LSB     = 8;
  localparam int WIN_W       = CTRL_W - WIN_LSB;
  localparam int PRESENT_BIT = 4;
  localparam int NUM_EV      = 3;

  // bits that hold state in the control word
  localparam logic [CTRL_W-1:0] KEEP_MASK =
    ({CTRL_W{1'b1}} << WIN_LSB) | CTRL_W'((1 << (MODE_BIT + 1)) - 1);
endpackage

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [WIN_W-1:0]  timer_q,
  output logic              clr_o,
  output logic              count_en_o
);
  logic [CTRL_W-1:0] stored;
  logic              run_tmr;
  logic              win_open;

  always_comb begin
    stored = wdata & KEEP_MASK;
    if (!wdata[TEN_BIT]) stored[CTRL_W-1:WIN_LSB] = '0;
  end

  assign clr_o    = we && wdata[RUN_BIT] && !ctrl_q[RUN_BIT];
  assign run_tmr  = ctrl_q[RUN_BIT] && ctrl_q[TEN_BIT];
  assign win_open = (timer_q != '0);

  always_comb begin
    if (!ctrl_q[RUN_BIT])       count_en_o = 1'b0;
    else if (ctrl_q[MODE_BIT])  count_en_o = ctrl_q[TEN_BIT] && win_open;
    else                        count_en_o = !ctrl_q[TEN_BIT] || win_open;
  end

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (we) ctrl_q <= stored;
  end

  always_ff @(posedge clk) begin
    if (rst)                      timer_q <= '0;
    else if (clr_o)               timer_q <= stored[CTRL_W-1:WIN_LSB];
    else if (run_tmr && win_open) timer_q <= timer_q - 1'b1;
  end

  // R6
  timer_dec_chk: assert property (@(posedge clk) disable iff (rst)
    run_tmr && win_open && !clr_o |=> timer_q == $past(timer_q) - 1'b1);
  // R6
  timer_floor_chk: assert property (@(posedge clk) disable iff (rst)
    !win_open && !clr_o |=> !win_open);
  // R3
  win_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[TEN_BIT] |-> ctrl_q[CTRL_W-1:WIN_LSB] == '0);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[RUN_BIT] && !clr_o |=> $stable(timer_q));
endmodule

// File: rtl/pmon_sat_cnt.sv
module pmon_sat_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc && !clr && cnt != TOP |=> cnt == $past(cnt) + CNT_W'(1));
  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cnt == TOP && !clr |=> cnt == TOP);
  // R9
  no_inc_chk: assert property (@(posedge clk) disable iff (rst)
    !inc && !clr |=> $stable(cnt));
endmodule

// File: rtl/cache_perf_mon.sv
module cache_perf_mon
  import pmon_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  input  logic              ev_hit,
  input  logic              ev_miss,
  input  logic              ev_byp,
  output logic [31:0]       ctrl_rdata,
  output logic [31:0]       build_cfg,
  output logic [23:0]       timer_left,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  byp_count
);
  assign build_cfg = PRESENT ? (32'd1 << PRESENT_BIT) : 32'd0;

  if (PRESENT) begin : g_mon
    logic              clr, cnt_en;
    logic [NUM_EV-1:0] evs;
    logic [CNT_W-1:0]  cnts [NUM_EV];

    assign evs = {ev_byp, ev_miss, ev_hit};

    pmon_ctrl u_ctrl (
      .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata),
      .ctrl_q(ctrl_rdata), .timer_q(timer_left),
      .clr_o(clr), .count_en_o(cnt_en)
    );

    for (genvar i = 0; i < NUM_EV; i++) begin : g_cnt
      pmon_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr),
        .inc(cnt_en && evs[i]), .cnt(cnts[i])
      );
    end

    assign hit_count  = cnts[0];
    assign miss_count = cnts[1];
    assign byp_count  = cnts[2];
  end else begin : g_absent
    logic unused_inputs;
    assign unused_inputs = ^{clk, rst, ctrl_we, ctrl_wdata, ev_hit, ev_miss, ev_byp};
    assign ctrl_rdata = '0;
    assign timer_left = '0;
    assign hit_count  = '0;
    assign miss_count = '0;
    assign byp_count  = '0;
  end
endmodule

// File: tb/cache_perf_mon_tb_top.sv
`timescale 1ns/1ps
module cache_perf_mon_tb_top;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic ev_hit = 1'b0, ev_miss = 1'b0, ev_byp = 1'b0;

  logic [31:0] ctrl_rdata, build_cfg, a_ctrl, a_cfg;
  logic [23:0] timer_left, a_tmr;
  logic [CW-1:0] hit_count, miss_count, byp_count, a_h, a_m, a_b;

  always #2 clk = ~clk;

  cache_perf_mon #(.CNT_W(CW), .PRESENT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_byp(ev_byp),
    .ctrl_rdata(ctrl_rdata), .build_cfg(build_cfg), .timer_left(timer_left),
    .hit_count(hit_count), .miss_count(miss_count), .byp_count(byp_count));

  cache_perf_mon #(.CNT_W(CW), .PRESENT(1'b0)) dut_absent_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_byp(ev_byp),
    .ctrl_rdata(a_ctrl), .build_cfg(a_cfg), .timer_left(a_tmr),
    .hit_count(a_h), .miss_count(a_m), .byp_count(a_b));

  typedef struct {
    logic [31:0]   ctrl;
    logic [23:0]   tmr;
    logic [CW-1:0] h, m, b;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;

  // reference model state
  logic [31:0]   m_ctrl = '0;
  logic [23:0]   m_tmr  = '0;
  logic [CW-1:0] m_h = '0, m_m = '0, m_b = '0;

  function automatic logic [CW-1:0] bump(logic [CW-1:0] v, logic go);
    return (go && v != {CW{1'b1}}) ? v + 1'b1 : v;
  endfunction

  task automatic step(input logic we, input logic [31:0] wd,
                      input logic h, input logic m, input logic b, input string tag);
    logic en, te, md, gate, rise;
    logic [31:0] st;
    exp_t e;
    @(negedge clk);
    ctrl_we = we; ctrl_wdata = wd; ev_hit = h; ev_miss = m; ev_byp = b;
    @(posedge clk);
    en = m_ctrl[0]; te = m_ctrl[1]; md = m_ctrl[2];
    gate = en && (md ? (te && m_tmr != 0) : (!te || m_tmr != 0));
    st = wd & 32'hFFFF_FF07;
    if (!wd[1]) st[31:8] = '0;
    rise = we && wd[0] && !en;
    if (rise) begin
      m_h = '0; m_m = '0; m_b = '0; m_tmr = st[31:8];
    end else begin
      m_h = bump(m_h, gate && h);
      m_m = bump(m_m, gate && m);
      m_b = bump(m_b, gate && b);
      if (en && te && m_tmr != 0) m_tmr = m_tmr - 1'b1;
    end
    if (we) m_ctrl = st;
    e.ctrl = m_ctrl; e.tmr = m_tmr; e.h = m_h; e.m = m_m; e.b = m_b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(ctrl_rdata, e.ctrl, e.tag, "ctrl");
      cmp({8'h0, timer_left}, {8'h0, e.tmr}, e.tag, "timer");
      cmp(32'(hit_count),  32'(e.h), e.tag, "hit");
      cmp(32'(miss_count), 32'(e.m), e.tag, "miss");
      cmp(32'(byp_count),  32'(e.b), e.tag, "bypass");
      cmp(build_cfg, 32'h10, "R11", "cfg present");
      cmp(a_cfg, 32'h0, "R11", "cfg absent");
      cmp(a_ctrl | {8'h0, a_tmr} | 32'(a_h) | 32'(a_m) | 32'(a_b), 32'h0, "R11", "absent outs");
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 1, 1, "R1");
    // R3 window dropped when timer disabled; R4 event in enabling cycle dropped
    step(1, 32'h0055_00F9, 1, 1, 1, "R3_R4");
    // R5 patterns, simultaneous pulses independent
    step(0, 0, 1, 0, 0, "R5");
    step(0, 0, 1, 1, 1, "R5");
    step(0, 0, 0, 1, 1, "R5");
    step(0, 0, 1, 0, 1, "R5");
    step(0, 0, 0, 0, 0, "R5");
    // R2 rewrite with run still set: mode 1, no timer, no clear
    step(1, 32'h0000_0005, 1, 1, 0, "R2");
    // R8 mode 1 without timer counts nothing
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, "R8");
    step(1, 32'h0000_0001, 0, 0, 0, "R2");
    // R9 stop: event at stop edge still counted, then ignored
    step(1, 32'h0000_0000, 1, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, "R9");
    // R6 R7 mode 0 with a 5-cycle window
    step(1, 32'h0000_0503, 0, 0, 0, "R7");
    for (int i = 0; i < 8; i++) step(0, 0, 1, 1, 1, "R6_R7");
    step(1, 0, 0, 0, 0, "R9");
    // R8 mode 1 with a 3-cycle window
    step(1, 32'h0000_0307, 0, 0, 0, "R8");
    for (int i = 0; i < 6; i++) step(0, 0, 1, i[0], 1, "R8");
    step(1, 0, 0, 0, 0, "R9");
    // R9 timer holds mid-window when stopped
    step(1, 32'h0000_1403, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R6");
    step(1, 32'h0000_1402, 0, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, "R9");
    // R10 saturation, free-running mode
    step(1, 32'h0000_0001, 0, 0, 0, "R7");
    for (int i = 0; i < 70; i++) step(0, 0, 1, i[0], 0, "R10");
    step(0, 0, 0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule